// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog timer that software must service on a regular basis. A 16-bit down-counter advances through a prescaler that divides the master clock by one of four fixed ratios. If software does not restart the count in time, the counter expires. On expiry the block can raise an interrupt request, a reset pulse of fixed length, or both. Which of these happen depends on two enable bits.

Software controls the block through four word-wide write locations on a simple register port. Each write must carry a 12-bit access key in bits 31:20. A key that does not match the location being written leaves the block unchanged. The control locations are:
- a mode word that holds the enables;
- a clock word that holds the prescaler code and the 4-bit high reload field;
- a restart word that reloads the count;
- a status word that clears a pending interrupt.

The intended start-up order is: disable with a keyed mode write, program the clock word, restart, then enable with a second keyed mode write. A read port returns the mode, the clock word, the live count and the pending interrupt flag.

Top module: `kwdt_top`

## Requirements
- R1: After reset, both outputs are low and the readbacks hold fixed values. The mode readback is 0. The clock readback is 0x3F (code 3, high field 0xF). The count readback is 0xFFFF. The status readback is 0.
- R2: Write location 0 (mode) takes key 0x5A1 in bits 31:20. A keyed write loads watchdog enable from bit 0, reset enable from bit 1 and interrupt enable from bit 2. Read location 0 returns these three bits in the same positions. A write to location 0 with any other key changes nothing.
- R3: Write location 1 (clock) takes key 0x3C7. A keyed write loads the prescaler code from bits 1:0 and the high reload field from bits 5:2. Read location 1 returns these six bits. Any other key changes nothing.
- R4: Write location 2 (restart) takes key 0xC55. A keyed write loads the counter with the high field in bits 15:12 and ones in bits 11:0. It also restarts the prescaler. Read location 2 returns the count in bits 15:0.
- R5: While watchdog enable is set, the counter advances once every 8, 32, 128 or 1024 master-clock cycles, for prescaler codes 0, 1, 2 and 3. The first advance comes that many cycles after the enabling write or the restart.
- R6: While watchdog enable is clear, neither the counter nor the prescaler moves.
- R7: A prescaler tick that finds the counter at zero is an expiry. The counter then reloads the preset value. Starting from preset P, expiry comes (P+1) × ratio cycles after enabling.
- R8: An expiry with interrupt enable set raises the interrupt output. The output stays high until a keyed write to location 3 (status, key 0x9E2) with bit 0 set. Such a write with bit 0 clear has no effect.
- R9: An expiry with reset enable set drives the reset output high for exactly RST_LEN master-clock cycles (default 4). The pulse starts on the cycle after the expiring tick.
- R10: An expiry whose interrupt enable or reset enable is clear does not assert that output.
- R11: Restart and status writes with a wrong key have no effect on the count or on the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 2 | Write location: 0 mode, 1 clock, 2 restart, 3 status |
| wr_data | input | 32 | Write word; key in bits 31:20, fields in low bits |
| rd_addr | input | 2 | Read location, same numbering as writes |
| rd_data | output | 32 | Combinational readback of the selected location |
| wdt_irq | output | 1 | Pending expiry interrupt, sticky |
| wdt_rst | output | 1 | Expiry reset pulse |

## Verification
The properties assume a single-word write port with at most one write per cycle. They also assume reset is held long enough to clear every register before the first write. Under those assumptions a restart never coincides with a clock write in the same cycle. The random phase keeps the enable bit clear in every mode write it issues, so the counter can change only through restarts. This lets the bench model the count exactly, while random keys and data exercise every write location. Timed expiry, prescaler ratios and output pulses are covered by directed sequences that follow the documented start-up order.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int DATA_W  = 32;
    localparam int KEY_W   = 12;
    localparam int KEY_LSB = DATA_W - KEY_W;
    localparam int CNT_W   = 16;
    localparam int HP_W    = 4;
    localparam int SEL_W   = 2;
    localparam int CFG_W   = HP_W + SEL_W;
    localparam int PRE_W   = 10;

    typedef enum logic [1:0] {
        LOC_MODE    = 2'd0,
        LOC_CLOCK   = 2'd1,
        LOC_RESTART = 2'd2,
        LOC_STATUS  = 2'd3
    } loc_e;

    typedef struct packed {
        logic irq_en;
        logic rst_en;
        logic wd_en;
    } mode_t;

    typedef struct packed {
        logic [HP_W-1:0]  hp;
        logic [SEL_W-1:0] sel;
    } clkcfg_t;

    localparam logic [KEY_W-1:0] MODE_KEY    = 12'h5A1;
    localparam logic [KEY_W-1:0] CLOCK_KEY   = 12'h3C7;
    localparam logic [KEY_W-1:0] RESTART_KEY = 12'hC55;
    localparam logic [KEY_W-1:0] STATUS_KEY  = 12'h9E2;

    localparam clkcfg_t CLK_RESET = '1;

    // last prescaler count before a tick
    function automatic logic [PRE_W-1:0] prescale_limit(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return PRE_W'(7);
            2'd1:    return PRE_W'(31);
            2'd2:    return PRE_W'(127);
            default: return PRE_W'(1023);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] preset_value(input logic [HP_W-1:0] hp);
        return {hp, {(CNT_W-HP_W){1'b1}}};
    endfunction

    function automatic logic key_ok(input logic [DATA_W-1:0] word,
                                    input logic [KEY_W-1:0]  key);
        return word[DATA_W-1:KEY_LSB] == key;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode_q,
    output clkcfg_t           clk_q,
    output logic              restart_p,
    output logic              clear_p
);
    loc_e loc;
    logic mode_hit, clock_hit, restart_hit, status_hit;
    logic unused_data;

    assign loc         = loc_e'(wr_addr);
    assign mode_hit    = wr_en && (loc == LOC_MODE)    && key_ok(wr_data, MODE_KEY);
    assign clock_hit   = wr_en && (loc == LOC_CLOCK)   && key_ok(wr_data, CLOCK_KEY);
    assign restart_hit = wr_en && (loc == LOC_RESTART) && key_ok(wr_data, RESTART_KEY);
    assign status_hit  = wr_en && (loc == LOC_STATUS)  && key_ok(wr_data, STATUS_KEY);

    assign restart_p   = restart_hit;
    assign clear_p     = status_hit && wr_data[0];
    assign unused_data = ^wr_data[KEY_LSB-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            clk_q  <= CLK_RESET;
        end else begin
            if (mode_hit)
                mode_q <= mode_t'(wr_data[$bits(mode_t)-1:0]);
            if (clock_hit)
                clk_q  <= clkcfg_t'(wr_data[CFG_W-1:0]);
        end
    end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    assign limit = prescale_limit(sel);
    // >= keeps a ratio change mid-count from skipping a whole wrap
    assign tick  = run && !restart && (pre_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [HP_W-1:0]  hp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    assign expire = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '1;
        else if (restart || expire)
            cnt_q <= preset_value(hp);
        else if (tick)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/kwdt_expiry.sv
module kwdt_expiry
    import kwdt_pkg::*;
#(
    parameter int RST_LEN = 4
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  expire,
    input  mode_t mode_q,
    input  logic  clear_p,
    output logic  irq,
    output logic  rst_out
);
    localparam int LEN_W = $clog2(RST_LEN + 1);

    logic [LEN_W-1:0] pulse_left;

    assign rst_out = (pulse_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            pulse_left <= '0;
        end else begin
            // a new expiry wins over a clear in the same cycle
            if (expire && mode_q.irq_en)
                irq <= 1'b1;
            else if (clear_p)
                irq <= 1'b0;

            if (expire && mode_q.rst_en)
                pulse_left <= LEN_W'(RST_LEN);
            else if (pulse_left != '0)
                pulse_left <= pulse_left - 1'b1;
        end
    end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int RST_LEN = 4
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        wdt_irq,
    output logic        wdt_rst
);
    mode_t            mode_q;
    clkcfg_t          clk_q;
    logic             restart_p;
    logic             clear_p;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;

    kwdt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode_q    (mode_q),
        .clk_q     (clk_q),
        .restart_p (restart_p),
        .clear_p   (clear_p)
    );

    kwdt_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_q.wd_en),
        .restart (restart_p),
        .sel     (clk_q.sel),
        .tick    (tick)
    );

    kwdt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart_p),
        .hp      (clk_q.hp),
        .cnt_q   (cnt_q),
        .expire  (expire)
    );

    kwdt_expiry #(.RST_LEN(RST_LEN)) u_exp (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .mode_q  (mode_q),
        .clear_p (clear_p),
        .irq     (wdt_irq),
        .rst_out (wdt_rst)
    );

    always_comb begin
        rd_data = '0;
        case (loc_e'(rd_addr))
            LOC_MODE:    rd_data[$bits(mode_t)-1:0] = mode_q;
            LOC_CLOCK:   rd_data[CFG_W-1:0]         = clk_q;
            LOC_RESTART: rd_data[CNT_W-1:0]         = cnt_q;
            LOC_STATUS:  rd_data[0]                 = wdt_irq;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int RST_LEN = 4
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input mode_t             mode_q,
    input clkcfg_t           clk_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              wdt_irq,
    input logic              wdt_rst
);
    localparam int HI_W = $clog2(RST_LEN + 1) + 1;

    logic [KEY_W-1:0] key;
    logic             good_restart, good_clear, bad_mode, bad_clock;
    logic [HI_W-1:0]  hi_cnt;
    logic             unused_bits;

    assign key          = wr_data[DATA_W-1:KEY_LSB];
    assign good_restart = wr_en && wr_addr == 2'd2 && key == RESTART_KEY;
    assign good_clear   = wr_en && wr_addr == 2'd3 && key == STATUS_KEY && wr_data[0];
    assign bad_mode     = wr_en && wr_addr == 2'd0 && key != MODE_KEY;
    assign bad_clock    = wr_en && wr_addr == 2'd1 && key != CLOCK_KEY;
    assign unused_bits  = ^wr_data[KEY_LSB-1:1];

    // consecutive high cycles of the reset output seen before this one
    always_ff @(posedge clk) begin
        if (rst || !wdt_rst)
            hi_cnt <= '0;
        else if (hi_cnt < HI_W'(RST_LEN + 1))
            hi_cnt <= hi_cnt + 1'b1;
    end

    // R2
    mode_key_chk: assert property (@(posedge clk) disable iff (rst)
        bad_mode |=> $stable(mode_q));

    // R3
    clock_key_chk: assert property (@(posedge clk) disable iff (rst)
        bad_clock |=> $stable(clk_q));

    // R4
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        good_restart |=> cnt_q == preset_value($past(clk_q.hp)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.wd_en && !good_restart) |=> $stable(cnt_q));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wdt_irq && !good_clear) |=> wdt_irq);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> $past(mode_q.irq_en));

    // R10
    rst_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst) |-> $past(mode_q.rst_en));

    // R9
    rst_len_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> hi_cnt < HI_W'(RST_LEN));
endmodule

bind kwdt_top kwdt_checker #(.RST_LEN(RST_LEN)) u_kwdt_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .clk_q   (clk_q),
    .cnt_q   (cnt_q),
    .wdt_irq (wdt_irq),
    .wdt_rst (wdt_rst)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/10ps
module kwdt_top_bench;
    localparam logic [11:0] K_MODE = 12'h5A1;
    localparam logic [11:0] K_CLK  = 12'h3C7;
    localparam logic [11:0] K_RST  = 12'hC55;
    localparam logic [11:0] K_STAT = 12'h9E2;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wdt_irq, wdt_rst;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    kwdt_top #(.RST_LEN(PULSE)) u_kwdt_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    function automatic logic [11:0] key_for(input logic [1:0] a);
        case (a)
            2'd0: return K_MODE;
            2'd1: return K_CLK;
            2'd2: return K_RST;
            default: return K_STAT;
        endcase
    endfunction

    function automatic int ratio_of(input int s);
        case (s)
            0: return 8;
            1: return 32;
            2: return 128;
            default: return 1024;
        endcase
    endfunction

    function automatic logic [15:0] preset_of(input logic [3:0] hp);
        return {hp, 12'hFFF};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] k, input logic [19:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = {k, d};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired before the bench ended");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        logic [2:0]  mode_m;
        logic [1:0]  sel_m;
        logic [3:0]  hp_m;
        logic [15:0] cnt_m;
        int          n, h;
        logic        saw;

        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 mode", v, 32'h0);
        rd(2'd1, v); chk("R1 clock", v, 32'h3F);
        rd(2'd2, v); chk("R1 count", v, 32'hFFFF);
        rd(2'd3, v); chk("R1 status", v, 32'h0);
        chk("R1 outputs", {30'b0, wdt_irq, wdt_rst}, 32'h0);

        // random keyed and unkeyed writes with the watchdog held disabled
        mode_m = '0; sel_m = 2'd3; hp_m = 4'hF; cnt_m = 16'hFFFF;
        for (int i = 0; i < 150; i++) begin
            logic [1:0]  a;
            logic [11:0] k;
            logic [19:0] d;
            a = 2'($urandom_range(0, 3));
            k = ($urandom_range(0, 1) == 1) ? key_for(a) : 12'($urandom);
            d = 20'($urandom);
            if (a == 2'd0) d[0] = 1'b0;
            wr(a, k, d);
            if (k == key_for(a)) begin
                case (a)
                    2'd0: mode_m = d[2:0];
                    2'd1: begin sel_m = d[1:0]; hp_m = d[5:2]; end
                    2'd2: cnt_m = preset_of(hp_m);
                    default: ;
                endcase
            end
            rd(2'd0, v); chk("R2 mode random", v, {29'b0, mode_m});
            rd(2'd1, v); chk("R3 clock random", v, {26'b0, hp_m, sel_m});
            rd(2'd2, v); chk("R4 count random", v, {16'b0, cnt_m});
            rd(2'd3, v); chk("R11 status random", v, 32'h0);
        end

        // R2 directed: enabling write with a wrong key is dropped
        wr(2'd0, 12'h5A0, 20'h7);
        rd(2'd0, v); chk("R2 bad key mode", v, {29'b0, mode_m});

        // R5 ratios and R6 hold
        for (int s = 0; s < 4; s++) begin
            int r, nn;
            r  = ratio_of(s);
            nn = (s + 2) * r + 1;
            wr(2'd0, K_MODE, 20'h0);
            wr(2'd1, K_CLK, 20'(s));
            wr(2'd2, K_RST, 20'h0);
            wr(2'd0, K_MODE, 20'h1);
            repeat (nn) @(posedge clk);
            #1;
            rd(2'd2, v);
            chk("R5 ratio count", v, 32'(16'hFFF - 16'(s + 2)));
            wr(2'd0, K_MODE, 20'h0);
            rd(2'd2, v);
            repeat (300) @(posedge clk);
            #1;
            rd(2'd2, v2);
            chk("R6 disabled hold", v2, v);
        end

        // R7 / R8 / R10 expiry with interrupt only
        wr(2'd0, K_MODE, 20'h0);
        wr(2'd1, K_CLK, 20'h0);
        wr(2'd2, K_RST, 20'h0);
        wr(2'd0, K_MODE, 20'h5);
        n = 0; saw = 1'b0;
        while (!wdt_irq && n < 40000) begin
            @(posedge clk); #1; n++;
            if (wdt_rst) saw = 1'b1;
        end
        chk("R7 expiry cycles", 32'(n), 32'd32768);
        chk("R10 no reset pulse", {31'b0, saw}, 32'h0);
        rd(2'd2, v); chk("R7 reload", v, 32'h0FFF);
        repeat (50) @(posedge clk);
        #1;
        chk("R8 irq held", {31'b0, wdt_irq}, 32'h1);
        wr(2'd3, 12'h123, 20'h1);
        chk("R11 bad status key", {31'b0, wdt_irq}, 32'h1);
        wr(2'd2, 12'h0C5, 20'h0);
        rd(2'd2, v);
        chk("R11 bad restart key", {31'b0, (v[15:0] < 16'h0FFF) ? 1'b1 : 1'b0}, 32'h1);
        wr(2'd3, K_STAT, 20'h0);
        chk("R8 clear needs bit0", {31'b0, wdt_irq}, 32'h1);
        wr(2'd3, K_STAT, 20'h1);
        chk("R8 cleared", {31'b0, wdt_irq}, 32'h0);

        // R9 / R10 expiry with reset only
        wr(2'd0, K_MODE, 20'h0);
        wr(2'd2, K_RST, 20'h0);
        wr(2'd0, K_MODE, 20'h3);
        n = 0;
        while (!wdt_rst && n < 40000) begin
            @(posedge clk); #1; n++;
        end
        chk("R9 reset after expiry", 32'(n), 32'd32768);
        h = 1;
        while (wdt_rst && h < 20) begin
            @(posedge clk); #1;
            if (wdt_rst) h++;
        end
        chk("R9 pulse length", 32'(h), 32'(PULSE));
        chk("R10 no irq", {31'b0, wdt_irq}, 32'h0);

        finish_run();
    end
endmodule